// File: doc/BRIEF.md
# Lockable Configuration Register Bank with Multi-Bit Booleans

This block is a small control and status register bank for a security peripheral. Software reaches it through a simple single-cycle register port with a write strobe, an address and write data. Reads are combinational on the address. The bank holds a one-way configuration lock and a control register made of three 4-bit multi-bit boolean fields. It also holds a software-owned error-injection test word and a sticky recoverable-alert status register.

Each control field accepts only two codes: 4'h6 for true and 4'h9 for false. Any other code written into a field is still stored, so the field then reads as "not true". The write also raises a one-cycle recoverable alert and sets that field's sticky status bit. Software repairs the setting by writing a legal configuration and clearing the status with write-1-to-clear. Two read windows expose generated data and internal state from the surrounding logic. Each window opens only when an 8-bit multi-bit enable from another party equals 8'h96 and the matching control field is true.

Top module: `lcr_top`

## Requirements
- R1: After reset the lock reads 1, the control register reads 0x999 (every field false), and the test register and status register read 0. The alert output is low.
- R2: Address 0 bit 0 is the lock. Writing 0 clears it. Writing 1 never sets it again once it is cleared.
- R3: While the lock is 0, writes to the control register (address 1) and to the test register (address 2) change nothing and raise no alert. While the lock is 1, the test register stores the full write word.
- R4: The control register has three fields: enable in bits [3:0], software-application read enable in bits [7:4], and internal-state read enable in bits [11:8]. A write with all three fields legal is stored as written and raises no alert.
- R5: A control write in which field i holds neither 4'h6 nor 4'h9 is stored as written. It sets status bit i (address 3) and drives the alert output high for exactly the one cycle after the write edge.
- R6: Status bits stay set until software writes 1 to them at address 3. Bits written with 0 keep their value.
- R7: A read of address 4 returns the generated-data input only when the external enable equals 8'h96 and bits [7:4] equal 4'h6. Otherwise it returns 0.
- R8: A read of address 5 returns the internal-state input only when the external enable equals 8'h96 and bits [11:8] equal 4'h6. Otherwise it returns 0.
- R9: Reads of unmapped addresses (6 and 7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wrEn_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| extEnable_i | input | EW | Second-party multi-bit read enable |
| genData_i | input | DW | Generated data offered for software reads |
| stateData_i | input | DW | Internal state offered for software reads |
| recovAlert_o | output | 1 | One-cycle recoverable alert pulse |
| errTest_o | output | DW | Error-injection test word |

## Verification
A lock stuck at 1 would show the first time a control write after locking reads back changed. A lock that reopens would show the same way. A field decoded with the wrong code value would show in the read window of the same cycle, because the gate is combinational. It would also show as an alert, or a missing one, one cycle after the write edge. A status bit that clears wrongly or fails to stick shows on the next status read. Each scenario reads back the affected register straight after the write that could have changed it.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam logic [3:0] MB4_TRUE  = 4'h6;
  localparam logic [3:0] MB4_FALSE = 4'h9;
  localparam logic [7:0] MB8_TRUE  = 8'h96;
  localparam logic [7:0] MB8_FALSE = 8'h69;

  localparam int ADDR_LOCK  = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_TEST  = 2;
  localparam int ADDR_STS   = 3;
  localparam int ADDR_GEN   = 4;
  localparam int ADDR_STATE = 5;

  localparam int FLD_SWAPP = 1;
  localparam int FLD_RDST  = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOCK, RD_CTRL, RD_TEST, RD_STS, RD_GEN, RD_STATE
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrTest;
    logic   wrClr;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/lcr_ctrl.sv
module lcr_ctrl import lcr_pkg::*; #(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrEn_i,
  input  logic [AW-1:0] addr_i,
  input  logic          lockBit_i,
  output logic          lockQ_o,
  output strobe_t       strobe_o
);
  logic lockQ;
  logic hitLock, hitCtrl, hitTest, hitSts, hitGen, hitState;

  assign hitLock  = addr_i == AW'(ADDR_LOCK);
  assign hitCtrl  = addr_i == AW'(ADDR_CTRL);
  assign hitTest  = addr_i == AW'(ADDR_TEST);
  assign hitSts   = addr_i == AW'(ADDR_STS);
  assign hitGen   = addr_i == AW'(ADDR_GEN);
  assign hitState = addr_i == AW'(ADDR_STATE);

  // one-way lock: only a write of 0 changes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lockQ <= 1'b1;
    else if (wrEn_i && hitLock && !lockBit_i) lockQ <= 1'b0;
  end

  always_comb begin
    strobe_o.wrCtrl = wrEn_i && hitCtrl && lockQ;
    strobe_o.wrTest = wrEn_i && hitTest && lockQ;
    strobe_o.wrClr  = wrEn_i && hitSts;
    if (hitLock)       strobe_o.rdSel = RD_LOCK;
    else if (hitCtrl)  strobe_o.rdSel = RD_CTRL;
    else if (hitTest)  strobe_o.rdSel = RD_TEST;
    else if (hitSts)   strobe_o.rdSel = RD_STS;
    else if (hitGen)   strobe_o.rdSel = RD_GEN;
    else if (hitState) strobe_o.rdSel = RD_STATE;
    else               strobe_o.rdSel = RD_NONE;
  end

  assign lockQ_o = lockQ;
endmodule

// File: rtl/lcr_datapath.sv
module lcr_datapath import lcr_pkg::*; #(
  parameter int DW   = 32,
  parameter int NFLD = 3,
  parameter int FW   = 4,
  parameter int EW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobe_t          strobe_i,
  input  logic             lockQ_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [EW-1:0]    extEnable_i,
  input  logic [DW-1:0]    genData_i,
  input  logic [DW-1:0]    stateData_i,
  output logic [NFLD*FW-1:0] fieldsQ_o,
  output logic [DW-1:0]    testQ_o,
  output logic             alert_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int CW = NFLD * FW;

  logic [CW-1:0]   fieldsQ;
  logic [NFLD-1:0] stsQ;
  logic [NFLD-1:0] illegal;
  logic [NFLD-1:0] fieldTrue;
  logic [DW-1:0]   testQ;
  logic            alertQ;
  logic            extTrue;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    logic [FW-1:0] wField;
    assign wField       = wdata_i[i*FW +: FW];
    assign illegal[i]   = (wField != FW'(MB4_TRUE)) && (wField != FW'(MB4_FALSE));
    assign fieldTrue[i] = fieldsQ[i*FW +: FW] == FW'(MB4_TRUE);
  end

  assign extTrue = extEnable_i == EW'(MB8_TRUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fieldsQ <= {NFLD{FW'(MB4_FALSE)}};
      testQ   <= '0;
      stsQ    <= '0;
      alertQ  <= 1'b0;
    end else begin
      if (strobe_i.wrCtrl) fieldsQ <= wdata_i[CW-1:0];
      if (strobe_i.wrTest) testQ   <= wdata_i;
      stsQ   <= (stsQ & ~(strobe_i.wrClr ? wdata_i[NFLD-1:0] : '0))
              | (strobe_i.wrCtrl ? illegal : '0);
      alertQ <= strobe_i.wrCtrl && (|illegal);
    end
  end

  always_comb begin
    unique case (strobe_i.rdSel)
      RD_LOCK:  rdata_o = DW'(lockQ_i);
      RD_CTRL:  rdata_o = DW'(fieldsQ);
      RD_TEST:  rdata_o = testQ;
      RD_STS:   rdata_o = DW'(stsQ);
      RD_GEN:   rdata_o = (extTrue && fieldTrue[FLD_SWAPP]) ? genData_i : '0;
      RD_STATE: rdata_o = (extTrue && fieldTrue[FLD_RDST]) ? stateData_i : '0;
      default:  rdata_o = '0;
    endcase
  end

  assign fieldsQ_o = fieldsQ;
  assign testQ_o   = testQ;
  assign alert_o   = alertQ;
endmodule

// File: rtl/lcr_top.sv
module lcr_top import lcr_pkg::*; #(
  parameter int AW   = 3,
  parameter int DW   = 32,
  parameter int NFLD = 3,
  parameter int FW   = 4,
  parameter int EW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrEn_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [EW-1:0] extEnable_i,
  input  logic [DW-1:0] genData_i,
  input  logic [DW-1:0] stateData_i,
  output logic          recovAlert_o,
  output logic [DW-1:0] errTest_o
);
  strobe_t              strobe;
  logic                 lockQ;
  logic [NFLD*FW-1:0]   fieldsQ;

  lcr_ctrl #(.AW(AW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrEn_i    (wrEn_i),
    .addr_i    (addr_i),
    .lockBit_i (wdata_i[0]),
    .lockQ_o   (lockQ),
    .strobe_o  (strobe)
  );

  lcr_datapath #(.DW(DW), .NFLD(NFLD), .FW(FW), .EW(EW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .lockQ_i     (lockQ),
    .wdata_i     (wdata_i),
    .extEnable_i (extEnable_i),
    .genData_i   (genData_i),
    .stateData_i (stateData_i),
    .fieldsQ_o   (fieldsQ),
    .testQ_o     (errTest_o),
    .alert_o     (recovAlert_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker import lcr_pkg::*; #(
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int CW = 12,
  parameter int EW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wrEn_i,
  input logic [AW-1:0] addr_i,
  input logic [EW-1:0] extEnable_i,
  input logic [DW-1:0] rdata_o,
  input logic          recovAlert_o,
  input logic          lockQ,
  input logic [CW-1:0] fieldsQ
);
  p_lock_oneway_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lockQ |=> !lockQ);

  p_locked_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lockQ |=> $stable(fieldsQ));

  p_alert_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovAlert_o |-> $past(wrEn_i && addr_i == AW'(ADDR_CTRL) && lockQ));

  p_gen_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_GEN) && extEnable_i != EW'(MB8_TRUE)) |-> rdata_o == '0);

  p_state_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_STATE) && extEnable_i != EW'(MB8_TRUE)) |-> rdata_o == '0);
endmodule

bind lcr_top lcr_checker #(.AW(AW), .DW(DW), .CW(NFLD*FW), .EW(EW)) u_chk (.*);

// File: tb/sim_lcr_top.sv
`timescale 1ns/1ps
module sim_lcr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  ext = 8'h69;
  logic [31:0] gen = 32'hA5A5_0001;
  logic [31:0] st  = 32'h5A5A_0002;
  logic        alert;
  logic [31:0] errTest;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  lcr_top u0 (
    .clk_i(clk), .rst_ni(rstN), .wrEn_i(wrEn), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .extEnable_i(ext), .genData_i(gen), .stateData_i(st),
    .recovAlert_o(alert), .errTest_o(errTest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write; returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R1 lock", d, 1);
    rd(1, d); check("R1 ctrl", d, 32'h999);
    rd(2, d); check("R1 test", d, 0);
    rd(3, d); check("R1 sts", d, 0);
    check("R1 alert", {31'b0, alert}, 0);
    rd(6, d); check("R9 unmapped 6", d, 0);
    rd(7, d); check("R9 unmapped 7", d, 0);
  endtask

  task automatic t_legal_gate;
    logic [31:0] d;
    wr(1, 32'h669);
    check("R4 no alert", {31'b0, alert}, 0);
    rd(1, d); check("R4 ctrl readback", d, 32'h669);
    ext = 8'h96;
    rd(4, d); check("R7 gen open", d, gen);
    rd(5, d); check("R8 state open", d, st);
    ext = 8'h69;
    rd(4, d); check("R7 gen ext false", d, 0);
    rd(5, d); check("R8 state ext false", d, 0);
    ext = 8'h97;
    rd(4, d); check("R7 gen ext illegal", d, 0);
    ext = 8'h96;
    wr(1, 32'h699);
    rd(4, d); check("R7 gen field false", d, 0);
    rd(5, d); check("R8 state still open", d, st);
    wr(1, 32'h966);
    rd(5, d); check("R8 state field false", d, 0);
    rd(4, d); check("R7 gen open again", d, gen);
  endtask

  task automatic t_illegal;
    logic [31:0] d;
    wr(1, 32'h6A9);
    check("R5 alert high", {31'b0, alert}, 1);
    rd(3, d); check("R5 sts bit1", d, 32'h2);
    rd(1, d); check("R5 stored as written", d, 32'h6A9);
    rd(4, d); check("R7 gen closed on illegal field", d, 0);
    @(negedge clk);
    check("R5 alert one cycle", {31'b0, alert}, 0);
    wr(1, 32'h3A9);
    check("R5 alert again", {31'b0, alert}, 1);
    rd(3, d); check("R5 sts bits1,2", d, 32'h6);
    wr(1, 32'h669);
    check("R5 no alert on legal", {31'b0, alert}, 0);
    rd(3, d); check("R6 sticky", d, 32'h6);
    wr(3, 32'h2);
    rd(3, d); check("R6 w1c partial", d, 32'h4);
    wr(3, 32'h4);
    rd(3, d); check("R6 w1c clear", d, 0);
    rd(4, d); check("R4 legal config restored", d, gen);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(2, 32'hDEAD_BEEF);
    rd(2, d); check("R3 test stored", d, 32'hDEAD_BEEF);
    check("R3 test port", errTest, 32'hDEAD_BEEF);
    wr(0, 32'h1);
    rd(0, d); check("R2 write1 keeps 1", d, 1);
    wr(0, 32'h0);
    rd(0, d); check("R2 cleared", d, 0);
    wr(0, 32'h1);
    rd(0, d); check("R2 stays 0", d, 0);
    wr(1, 32'hAAA);
    check("R3 no alert when locked", {31'b0, alert}, 0);
    rd(1, d); check("R3 ctrl unchanged", d, 32'h669);
    rd(3, d); check("R3 sts unchanged", d, 0);
    wr(2, 32'h1234_5678);
    rd(2, d); check("R3 test unchanged", d, 32'hDEAD_BEEF);
  endtask

  initial begin
    #1000000;
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal_gate();
    t_illegal();
    t_lock();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule